// File: doc/BRIEF.md
# Wide-to-Narrow Bus Width Bridge

This block joins a 32-bit master port to a 16-bit slave port that uses Wishbone-style handshakes. Each wide access becomes a short run of narrow accesses in ascending lane order. Write data is split across the narrow accesses. Read data from each narrow access is placed back into the byte lanes it came from. The wide master receives a single termination at the end of the run.

A sideband bit arrives with each wide request. It says whether the addressed target is only a byte wide. For such a target, every selected wide byte becomes its own narrow access on the low data lane. Otherwise, each selected halfword becomes one narrow access.

Select patterns that cannot be split cleanly are refused with an error and cause no narrow traffic. A narrow error or retry stops the run and is handed back to the master. The narrow clock and reset are wired straight through from the wide side.

Top module: `bus_narrowing_bridge`

## Requirements
- R1: While reset is low, `n_cyc_o`, `n_stb_o`, `w_ack_o`, `w_err_o` and `w_rty_o` are all low. After reset the bridge waits idle for a request.
- R2: The legal values of `w_sel_i` are 0001, 0010, 0100, 1000, 0011, 1100 and 1111. Any other value, for example 0110, 0111 or 0000, raises `w_err_o` in the cycle after the request is accepted, and no narrow cycle is started.
- R3: When `byte_tgt_i` is low (halfword target), there is one narrow access for each halfword h (h = 0, 1) that has any select bit set, in ascending h. Its address is the wide address with bits [1:0] cleared, plus 2h. `n_sel_o` equals `w_sel_i[2h+1:2h]` and `n_wdat_o` equals `w_wdat_i[16h+15:16h]`.
- R4: When `byte_tgt_i` is high (byte target), there is one narrow access for each selected byte k, in ascending k. Its address is the aligned wide address plus k. `n_sel_o` is 01 and `n_wdat_o` is {8'h00, wide byte k}.
- R5: `n_cyc_o` stays high across all narrow accesses of one wide access. `n_stb_o` stays high, with `n_adr_o` stable, until the narrow access receives ack, err or rty.
- R6: On a read ack, every selected byte lane of `w_rdat_o` holds the byte read for it, and unselected lanes read zero. A byte target's data is taken from `n_rdat_i[7:0]` only; its upper byte is ignored.
- R7: `w_ack_o` is high for exactly one cycle, in the cycle after the narrow ack of the last access. `w_ack_o`, `w_err_o` and `w_rty_o` are never high together.
- R8: A narrow err ends the run with no further narrow accesses, and raises `w_err_o` for one cycle in the next cycle.
- R9: A narrow rty ends the run the same way and raises `w_rty_o` for one cycle in the next cycle.
- R10: `byte_tgt_i` is sampled only in the cycle the wide request is accepted. Changing it during the run has no effect.
- R11: `n_clk_o` follows `clk_i`, and `n_rst_no` follows `rst_ni`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| w_cyc_i | input | 1 | Wide bus cycle |
| w_stb_i | input | 1 | Wide strobe |
| w_we_i | input | 1 | Wide write enable |
| w_adr_i | input | 32 | Wide byte address |
| w_sel_i | input | 4 | Wide byte selects |
| w_wdat_i | input | 32 | Wide write data |
| w_rdat_o | output | 32 | Wide read data |
| w_ack_o | output | 1 | Wide normal termination |
| w_err_o | output | 1 | Wide error termination |
| w_rty_o | output | 1 | Wide retry termination |
| byte_tgt_i | input | 1 | Current target is byte wide |
| n_clk_o | output | 1 | Narrow clock (pass-through) |
| n_rst_no | output | 1 | Narrow reset, active low (pass-through) |
| n_cyc_o | output | 1 | Narrow bus cycle |
| n_stb_o | output | 1 | Narrow strobe |
| n_we_o | output | 1 | Narrow write enable |
| n_adr_o | output | 32 | Narrow byte address |
| n_sel_o | output | 2 | Narrow byte selects |
| n_wdat_o | output | 16 | Narrow write data |
| n_rdat_i | input | 16 | Narrow read data |
| n_ack_i | input | 1 | Narrow ack |
| n_err_i | input | 1 | Narrow error |
| n_rty_i | input | 1 | Narrow retry |

## Verification
Narrow strobe rises in the cycle after the wide request is taken. Each later narrow access starts in the cycle after the previous narrow ack. The wide termination falls exactly one cycle after the narrow ack, err or rty that ends the run, and an illegal select is refused one cycle after the request. The bench keeps a cycle count and records the cycle in which its slave model ends each narrow access. The wide-side monitor then checks that every termination appears in the cycle one after that record, or one after the request cycle for illegal selects. The slave delay is varied between 0 and 2 wait cycles, so that these offsets are tested against more than one narrow timing.

// File: rtl/bnb_pkg.sv
package bnb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_RESP = 2'd2
  } bnb_state_e;

  typedef enum logic [1:0] {
    RSP_ACK = 2'd0,
    RSP_ERR = 2'd1,
    RSP_RTY = 2'd2
  } bnb_resp_e;
endpackage

// File: rtl/bnb_lane_plan.sv
// Decides legality of a wide select pattern and which byte positions start
// a narrow sub-access (every selected byte, or the first byte of each touched group).
module bnb_lane_plan #(
  parameter int WB = 4,
  parameter int NB = 2
) (
  input  logic [WB-1:0] sel_i,
  input  logic          byte_tgt_i,
  output logic          legal_o,
  output logic [WB-1:0] mask_o
);
  localparam int NG = WB / NB;

  logic [NG-1:0] grp_any;
  logic [NG-1:0] grp_full;
  int unsigned   ones;

  for (genvar g = 0; g < NG; g++) begin : g_grp
    assign grp_any[g]  = |sel_i[g*NB +: NB];
    assign grp_full[g] = &sel_i[g*NB +: NB];
  end

  for (genvar k = 0; k < WB; k++) begin : g_mask
    if ((k % NB) == 0) begin : g_head
      assign mask_o[k] = byte_tgt_i ? sel_i[k] : grp_any[k/NB];
    end else begin : g_tail
      assign mask_o[k] = byte_tgt_i & sel_i[k];
    end
  end

  always_comb begin
    ones    = $countones(sel_i);
    legal_o = (&sel_i) || (ones == 1) || ((ones == NB) && (|grp_full));
  end
endmodule

// File: rtl/bnb_unit_sched.sv
// Picks the lowest enabled unit, either from the start or above the current one.
module bnb_unit_sched #(
  parameter int WB = 4,
  parameter int IW = $clog2(WB)
) (
  input  logic [WB-1:0] mask_i,
  input  logic [IW-1:0] cur_i,
  input  logic          from_start_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int k = WB - 1; k >= 0; k--) begin
      if (mask_i[k] && (from_start_i || (k > int'(cur_i)))) begin
        found_o = 1'b1;
        idx_o   = IW'(k);
      end
    end
  end
endmodule

// File: rtl/bnb_gather.sv
// Collects narrow read data into the selected byte lanes of the wide word.
module bnb_gather #(
  parameter int WB = 4,
  parameter int NB = 2,
  parameter int IW = $clog2(WB)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            load_i,
  input  logic            byte_mode_i,
  input  logic [IW-1:0]   idx_i,
  input  logic [WB-1:0]   sel_i,
  input  logic [8*NB-1:0] rdat_i,
  output logic [8*WB-1:0] word_o
);
  logic [8*WB-1:0] word_q;
  logic [8*WB-1:0] word_d;

  for (genvar l = 0; l < WB; l++) begin : g_lane
    localparam int OFS  = 8 * (l % NB);
    localparam int HEAD = l - (l % NB);
    logic       hit;
    logic [7:0] src;
    assign hit = byte_mode_i ? (idx_i == IW'(l)) : (idx_i == IW'(HEAD));
    assign src = byte_mode_i ? rdat_i[7:0] : rdat_i[OFS +: 8];
    assign word_d[8*l +: 8] = clr_i ? 8'h00 :
                              (load_i && sel_i[l] && hit) ? src : word_q[8*l +: 8];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) word_q <= '0;
    else         word_q <= word_d;
  end

  assign word_o = word_q;
endmodule

// File: rtl/bus_narrowing_bridge.sv
module bus_narrowing_bridge
  import bnb_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int WIDE_W   = 32,
  parameter int NARROW_W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                w_cyc_i,
  input  logic                w_stb_i,
  input  logic                w_we_i,
  input  logic [ADDR_W-1:0]   w_adr_i,
  input  logic [WIDE_W/8-1:0] w_sel_i,
  input  logic [WIDE_W-1:0]   w_wdat_i,
  output logic [WIDE_W-1:0]   w_rdat_o,
  output logic                w_ack_o,
  output logic                w_err_o,
  output logic                w_rty_o,
  input  logic                byte_tgt_i,
  output logic                n_clk_o,
  output logic                n_rst_no,
  output logic                n_cyc_o,
  output logic                n_stb_o,
  output logic                n_we_o,
  output logic [ADDR_W-1:0]   n_adr_o,
  output logic [NARROW_W/8-1:0] n_sel_o,
  output logic [NARROW_W-1:0] n_wdat_o,
  input  logic [NARROW_W-1:0] n_rdat_i,
  input  logic                n_ack_i,
  input  logic                n_err_i,
  input  logic                n_rty_i
);
  localparam int WB = WIDE_W / 8;
  localparam int NB = NARROW_W / 8;
  localparam int IW = $clog2(WB);

  // registered state
  bnb_state_e         state_q, state_d;
  bnb_resp_e          resp_q, resp_d;
  logic [IW-1:0]      idx_q, idx_d;
  logic [ADDR_W-IW-1:0] adr_q, adr_d;
  logic [WB-1:0]      sel_q, sel_d;
  logic [WB-1:0]      mask_q, mask_d;
  logic [WIDE_W-1:0]  wdat_q, wdat_d;
  logic               we_q, we_d;
  logic               mode_q, mode_d;

  logic               accept;
  logic               run;
  logic               plan_legal;
  logic [WB-1:0]      plan_mask;
  logic               first_found;
  logic [IW-1:0]      first_idx;
  logic               next_found;
  logic [IW-1:0]      next_idx;
  logic               gather_load;

  bnb_lane_plan #(.WB(WB), .NB(NB)) plan_i (
    .sel_i      (w_sel_i),
    .byte_tgt_i (byte_tgt_i),
    .legal_o    (plan_legal),
    .mask_o     (plan_mask)
  );

  bnb_unit_sched #(.WB(WB), .IW(IW)) first_i (
    .mask_i       (plan_mask),
    .cur_i        ('0),
    .from_start_i (1'b1),
    .found_o      (first_found),
    .idx_o        (first_idx)
  );

  bnb_unit_sched #(.WB(WB), .IW(IW)) next_i (
    .mask_i       (mask_q),
    .cur_i        (idx_q),
    .from_start_i (1'b0),
    .found_o      (next_found),
    .idx_o        (next_idx)
  );

  assign accept      = (state_q == ST_IDLE) && w_cyc_i && w_stb_i;
  assign run         = (state_q == ST_RUN);
  assign gather_load = run && n_ack_i && !n_err_i && !n_rty_i && !we_q;

  bnb_gather #(.WB(WB), .NB(NB), .IW(IW)) gather_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (accept),
    .load_i      (gather_load),
    .byte_mode_i (mode_q),
    .idx_i       (idx_q),
    .sel_i       (sel_q),
    .rdat_i      (n_rdat_i),
    .word_o      (w_rdat_o)
  );

  // next-state logic
  always_comb begin
    state_d = state_q;
    resp_d  = resp_q;
    idx_d   = idx_q;
    adr_d   = adr_q;
    sel_d   = sel_q;
    mask_d  = mask_q;
    wdat_d  = wdat_q;
    we_d    = we_q;
    mode_d  = mode_q;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          adr_d  = w_adr_i[ADDR_W-1:IW];
          sel_d  = w_sel_i;
          mask_d = plan_mask;
          wdat_d = w_wdat_i;
          we_d   = w_we_i;
          mode_d = byte_tgt_i;
          idx_d  = first_idx;
          if (plan_legal && first_found) begin
            state_d = ST_RUN;
          end else begin
            state_d = ST_RESP;
            resp_d  = RSP_ERR;
          end
        end
      end
      ST_RUN: begin
        if (n_err_i) begin
          state_d = ST_RESP;
          resp_d  = RSP_ERR;
        end else if (n_rty_i) begin
          state_d = ST_RESP;
          resp_d  = RSP_RTY;
        end else if (n_ack_i) begin
          if (next_found) begin
            idx_d = next_idx;
          end else begin
            state_d = ST_RESP;
            resp_d  = RSP_ACK;
          end
        end
      end
      ST_RESP: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      resp_q  <= RSP_ACK;
      idx_q   <= '0;
      adr_q   <= '0;
      sel_q   <= '0;
      mask_q  <= '0;
      wdat_q  <= '0;
      we_q    <= 1'b0;
      mode_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      resp_q  <= resp_d;
      idx_q   <= idx_d;
      adr_q   <= adr_d;
      sel_q   <= sel_d;
      mask_q  <= mask_d;
      wdat_q  <= wdat_d;
      we_q    <= we_d;
      mode_q  <= mode_d;
    end
  end

  // per-unit lane slices of captured write data and selects
  logic [7:0]          byte_wd  [WB];
  logic [NARROW_W-1:0] group_wd [WB];
  logic [NB-1:0]       group_sel[WB];

  for (genvar k = 0; k < WB; k++) begin : g_slice
    assign byte_wd[k] = wdat_q[8*k +: 8];
    if ((k % NB) == 0) begin : g_head
      assign group_wd[k]  = wdat_q[8*k +: NARROW_W];
      assign group_sel[k] = sel_q[k +: NB];
    end else begin : g_tail
      assign group_wd[k]  = '0;
      assign group_sel[k] = '0;
    end
  end

  // narrow side
  assign n_clk_o  = clk_i;
  assign n_rst_no = rst_ni;
  assign n_cyc_o  = run;
  assign n_stb_o  = run;
  assign n_we_o   = run && we_q;
  assign n_adr_o  = {adr_q, idx_q};
  assign n_sel_o  = !run ? '0 : (mode_q ? NB'(1) : group_sel[idx_q]);
  assign n_wdat_o = mode_q ? {{(NARROW_W-8){1'b0}}, byte_wd[idx_q]} : group_wd[idx_q];

  // wide terminations
  assign w_ack_o = (state_q == ST_RESP) && (resp_q == RSP_ACK);
  assign w_err_o = (state_q == ST_RESP) && (resp_q == RSP_ERR);
  assign w_rty_o = (state_q == ST_RESP) && (resp_q == RSP_RTY);
endmodule

// File: rtl/bnb_checker.sv
module bnb_checker #(
  parameter int WB = 4,
  parameter int AW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          w_cyc_i,
  input logic          w_stb_i,
  input logic [WB-1:0] w_sel_i,
  input logic          w_ack_o,
  input logic          w_err_o,
  input logic          w_rty_o,
  input logic          n_cyc_o,
  input logic          n_stb_o,
  input logic [AW-1:0] n_adr_o,
  input logic          n_ack_i,
  input logic          n_err_i,
  input logic          n_rty_i
);
  logic any_resp;
  logic take;
  logic sel_ok;

  assign any_resp = w_ack_o | w_err_o | w_rty_o;
  assign take     = w_cyc_i && w_stb_i && !n_cyc_o && !any_resp;
  assign sel_ok   = ($countones(w_sel_i) == 1) || (&w_sel_i) ||
                    (w_sel_i == {{(WB/2){1'b0}}, {(WB/2){1'b1}}}) ||
                    (w_sel_i == {{(WB/2){1'b1}}, {(WB/2){1'b0}}});

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      p_reset_idle_r1: assert (!n_cyc_o && !n_stb_o && !any_resp)
        else $error("idle outputs during reset");
    end
  end

  p_illegal_err_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take && !sel_ok |=> w_err_o && !n_cyc_o);

  p_legal_start_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take && sel_ok |=> n_cyc_o && n_stb_o);

  p_stb_in_cyc_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    n_stb_o |-> n_cyc_o);

  p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    n_stb_o && !n_ack_i && !n_err_i && !n_rty_i |=> n_stb_o && $stable(n_adr_o));

  p_ack_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    w_ack_o |=> !w_ack_o);

  p_resp_excl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({w_ack_o, w_err_o, w_rty_o}));

  p_ack_cause_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    w_ack_o |-> $past(n_ack_i && n_stb_o));

  p_err_cause_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    w_err_o |-> $past(n_err_i && n_stb_o) || $past(take && !sel_ok));

  p_rty_cause_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    w_rty_o |-> $past(n_rty_i && n_stb_o));
endmodule

bind bus_narrowing_bridge bnb_checker #(.WB(WIDE_W/8), .AW(ADDR_W)) chk_i (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .w_cyc_i (w_cyc_i),
  .w_stb_i (w_stb_i),
  .w_sel_i (w_sel_i),
  .w_ack_o (w_ack_o),
  .w_err_o (w_err_o),
  .w_rty_o (w_rty_o),
  .n_cyc_o (n_cyc_o),
  .n_stb_o (n_stb_o),
  .n_adr_o (n_adr_o),
  .n_ack_i (n_ack_i),
  .n_err_i (n_err_i),
  .n_rty_i (n_rty_i)
);

// File: tb/bus_narrowing_bridge_tb_top.sv
`timescale 1ns/1ps
module bus_narrowing_bridge_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        w_cyc_i = 0, w_stb_i = 0, w_we_i = 0, byte_tgt_i = 0;
  logic [31:0] w_adr_i = '0, w_wdat_i = '0;
  logic [3:0]  w_sel_i = '0;
  logic [31:0] w_rdat_o;
  logic        w_ack_o, w_err_o, w_rty_o;
  logic        n_clk_o, n_rst_no, n_cyc_o, n_stb_o, n_we_o;
  logic [31:0] n_adr_o;
  logic [1:0]  n_sel_o;
  logic [15:0] n_wdat_o;
  logic [15:0] n_rdat_i = '0;
  logic        n_ack_i = 0, n_err_i = 0, n_rty_i = 0;

  bus_narrowing_bridge dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .w_cyc_i(w_cyc_i), .w_stb_i(w_stb_i), .w_we_i(w_we_i), .w_adr_i(w_adr_i),
    .w_sel_i(w_sel_i), .w_wdat_i(w_wdat_i), .w_rdat_o(w_rdat_o),
    .w_ack_o(w_ack_o), .w_err_o(w_err_o), .w_rty_o(w_rty_o),
    .byte_tgt_i(byte_tgt_i), .n_clk_o(n_clk_o), .n_rst_no(n_rst_no),
    .n_cyc_o(n_cyc_o), .n_stb_o(n_stb_o), .n_we_o(n_we_o), .n_adr_o(n_adr_o),
    .n_sel_o(n_sel_o), .n_wdat_o(n_wdat_o), .n_rdat_i(n_rdat_i),
    .n_ack_i(n_ack_i), .n_err_i(n_err_i), .n_rty_i(n_rty_i)
  );

  typedef struct {
    logic [31:0] adr;
    logic [1:0]  sel;
    logic        we;
    logic [15:0] wdat;
    string       rq;
  } nitem_t;

  typedef struct {
    int          kind;   // 0 ack, 1 err, 2 rty
    logic        we;
    logic [31:0] rdat;
    int          due;    // -1: one cycle after the terminating narrow response
    string       rq;
  } witem_t;

  nitem_t nq[$];
  witem_t wq[$];
  logic [7:0] mem [64];

  int checks = 0;
  int errors = 0;
  int cyc_n = 0;
  int last_term_cyc = -10;
  int ncyc_seen = 0;
  int slv_delay = 0;
  int inj_adr = -1;
  int inj_kind = 0;
  logic cur_bt = 0;
  int wcnt = 0;

  task automatic chk(input string rq, input string what, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  always @(posedge clk) cyc_n++;

  // narrow slave model with expected-access scoreboard
  always begin
    @(posedge clk);
    #1;
    if (n_ack_i || n_err_i || n_rty_i) begin
      n_ack_i = 0; n_err_i = 0; n_rty_i = 0;
    end else if (n_cyc_o && n_stb_o) begin
      ncyc_seen++;
      if (wcnt < slv_delay) wcnt++;
      else begin
        logic [5:0] a;
        wcnt = 0;
        a = n_adr_o[5:0];
        if (nq.size() == 0) begin
          chk("R2", "unexpected narrow access", {32'h0, n_adr_o}, 64'hFFFF_FFFF);
        end else begin
          nitem_t e;
          e = nq.pop_front();
          chk(e.rq, "narrow adr/sel/we", {n_adr_o, n_sel_o, n_we_o}, {e.adr, e.sel, e.we});
          if (e.we) chk(e.rq, "narrow wdat", {48'h0, n_wdat_o}, {48'h0, e.wdat});
        end
        last_term_cyc = cyc_n;
        if (int'(n_adr_o) == inj_adr && inj_kind == 1) n_err_i = 1;
        else if (int'(n_adr_o) == inj_adr && inj_kind == 2) n_rty_i = 1;
        else begin
          if (n_we_o) begin
            if (n_sel_o[0]) mem[a] = n_wdat_o[7:0];
            if (n_sel_o[1] && !cur_bt) mem[a+6'd1] = n_wdat_o[15:8];
          end
          n_rdat_i = cur_bt ? {8'hEE, mem[a]} : {mem[a+6'd1], mem[a]};
          n_ack_i = 1;
        end
      end
    end else wcnt = 0;
  end

  // wide response monitor
  always @(negedge clk) begin
    if (rst_n && (w_ack_o || w_err_o || w_rty_o)) begin
      int k;
      k = w_err_o ? 1 : (w_rty_o ? 2 : 0);
      if (wq.size() == 0) chk("R7", "unexpected wide response", 64'(k), 64'hFF);
      else begin
        witem_t e;
        int due;
        e = wq.pop_front();
        due = (e.due < 0) ? last_term_cyc + 1 : e.due;
        chk(e.rq, "wide response kind", 64'(k), 64'(e.kind));
        chk(e.rq, "wide response cycle", 64'(cyc_n), 64'(due));
        if (e.kind == 0 && !e.we) chk(e.rq, "wide read data", {32'h0, w_rdat_o}, {32'h0, e.rdat});
      end
    end
  end

  task automatic xfer(input logic we, input logic [31:0] adr, input logic [3:0] sel,
                      input logic [31:0] wdat, input logic bt, input int dly,
                      input int inj_a, input int inj_k, input logic flip, input string rq);
    logic [31:0] base;
    logic        legal;
    logic [31:0] er;
    int          kind;
    bit          stop;
    int          ncyc0;
    witem_t      wi;
    base  = {adr[31:2], 2'b00};
    legal = (sel inside {4'b0001, 4'b0010, 4'b0100, 4'b1000, 4'b0011, 4'b1100, 4'b1111});
    kind  = legal ? 0 : 1;
    stop  = 0;
    er    = '0;
    if (legal) begin
      for (int u = 0; u < 4; u++) begin
        nitem_t it;
        bit use_it;
        use_it = 0;
        if (stop) continue;
        if (bt) begin
          if (sel[u]) begin
            it.adr = base + 32'(u); it.sel = 2'b01; it.wdat = {8'h00, wdat[8*u +: 8]};
            use_it = 1;
          end
        end else if ((u % 2) == 0 && sel[u +: 2] != 2'b00) begin
          it.adr = base + 32'(u); it.sel = sel[u +: 2]; it.wdat = wdat[8*u +: 16];
          use_it = 1;
        end
        if (use_it) begin
          it.we = we; it.rq = rq;
          nq.push_back(it);
          if (int'(it.adr) == inj_a) begin stop = 1; kind = inj_k; end
        end
      end
      for (int l = 0; l < 4; l++)
        if (sel[l]) er[8*l +: 8] = mem[6'(base + 32'(l))];
    end
    slv_delay = dly; inj_adr = inj_a; inj_kind = inj_k; cur_bt = bt;
    @(posedge clk);
    #1;
    wi.kind = kind; wi.we = we; wi.rdat = er; wi.rq = rq;
    wi.due  = legal ? -1 : cyc_n + 1;
    wq.push_back(wi);
    ncyc0 = ncyc_seen;
    w_cyc_i = 1; w_stb_i = 1; w_we_i = we; w_adr_i = adr; w_sel_i = sel;
    w_wdat_i = wdat; byte_tgt_i = bt;
    if (flip) begin
      @(posedge clk);
      #1;
      byte_tgt_i = ~bt;
    end
    do @(negedge clk); while (!(w_ack_o || w_err_o || w_rty_o));
    @(posedge clk);
    #1;
    w_cyc_i = 0; w_stb_i = 0; w_we_i = 0; byte_tgt_i = 0;
    chk(rq, "all expected narrow accesses issued", 64'(nq.size()), 64'd0);
    nq.delete();
    if (!legal) chk(rq, "no narrow cycle for illegal select", 64'(ncyc_seen - ncyc0), 64'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 8'(i * 29 + 7);
    repeat (2) @(negedge clk);
    // R1 / R11: reset state and pass-through
    chk("R1", "idle during reset",
        {59'h0, n_cyc_o, n_stb_o, w_ack_o, w_err_o, w_rty_o}, 64'h0);
    chk("R11", "narrow reset during reset", {63'h0, n_rst_no}, 64'h0);
    chk("R11", "narrow clock low phase", {63'h0, n_clk_o}, 64'h0);
    @(posedge clk);
    #1;
    rst_n = 1;
    chk("R11", "narrow clock high phase", {63'h0, n_clk_o}, 64'h1);
    @(negedge clk);
    chk("R11", "narrow reset released", {63'h0, n_rst_no}, 64'h1);
    chk("R1", "idle after reset", {62'h0, n_cyc_o, w_ack_o}, 64'h0);

    // R3 halfword target: full read, full write, read back
    xfer(0, 32'h1000_0000, 4'b1111, 32'h0, 0, 1, -1, 0, 0, "R3");
    xfer(1, 32'h1000_0000, 4'b1111, 32'hA1B2_C3D4, 0, 0, -1, 0, 0, "R3");
    xfer(0, 32'h1000_0000, 4'b1111, 32'h0, 0, 2, -1, 0, 0, "R6");
    // R3 aligned base ignores address bits [1:0]
    xfer(0, 32'h1000_0023, 4'b1100, 32'h0, 0, 0, -1, 0, 0, "R3");
    // R3 single byte and halfword on halfword target
    xfer(1, 32'h1000_0008, 4'b0010, 32'h0000_5A00, 0, 1, -1, 0, 0, "R3");
    xfer(1, 32'h1000_000C, 4'b1100, 32'h7E6D_0000, 0, 0, -1, 0, 0, "R3");
    xfer(0, 32'h1000_0008, 4'b0010, 32'h0, 0, 0, -1, 0, 0, "R6");
    xfer(0, 32'h1000_000C, 4'b1111, 32'h0, 0, 1, -1, 0, 0, "R6");

    // R4 byte target: full read, per-byte writes, read back
    xfer(0, 32'h2000_0010, 4'b1111, 32'h0, 1, 2, -1, 0, 0, "R4");
    for (int k = 0; k < 4; k++)
      xfer(1, 32'h2000_0014, 4'(1 << k), 32'h1122_3344 ^ 32'(k * 32'h0101_0101), 1, k % 2,
           -1, 0, 0, "R4");
    xfer(0, 32'h2000_0014, 4'b1111, 32'h0, 1, 0, -1, 0, 0, "R6");
    xfer(1, 32'h2000_0018, 4'b1100, 32'hBEEF_0000, 1, 1, -1, 0, 0, "R4");
    xfer(0, 32'h2000_0018, 4'b0011, 32'h0, 1, 0, -1, 0, 0, "R6");
    xfer(0, 32'h2000_0018, 4'b1100, 32'h0, 1, 2, -1, 0, 0, "R5");

    // R2 illegal selects
    xfer(1, 32'h3000_0020, 4'b0110, 32'hFFBA_ADFF, 0, 0, -1, 0, 0, "R2");
    xfer(0, 32'h3000_0020, 4'b0111, 32'h0, 1, 0, -1, 0, 0, "R2");
    xfer(0, 32'h3000_0020, 4'b0000, 32'h0, 0, 0, -1, 0, 0, "R2");

    // R8 narrow err aborts the run on its second byte
    xfer(0, 32'h0000_0028, 4'b1111, 32'h0, 1, 1, 32'h0000_0029, 1, 0, "R8");
    xfer(1, 32'h0000_0028, 4'b1111, 32'h0102_0304, 0, 0, 32'h0000_0028, 1, 0, "R8");
    // R9 narrow rty aborts on the upper halfword
    xfer(0, 32'h0000_0030, 4'b1111, 32'h0, 0, 1, 32'h0000_0032, 2, 0, "R9");
    // R7 normal completion after an abort
    xfer(0, 32'h0000_0030, 4'b1111, 32'h0, 0, 0, -1, 0, 0, "R7");

    // R10 sideband flipped after acceptance
    xfer(0, 32'h0000_0038, 4'b1111, 32'h0, 1, 1, -1, 0, 1, "R10");
    xfer(0, 32'h0000_0038, 4'b1111, 32'h0, 0, 1, -1, 0, 1, "R10");

    repeat (4) @(posedge clk);
    chk("R7", "no pending wide response", 64'(wq.size()), 64'd0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule